// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Single-Entry Buffer

This block takes in one asynchronous serial line and turns each character on it into a parallel word that a host can read. An oversampling strobe, usually sixteen pulses per bit period, paces the receiver. A falling edge on the idle-high line counts as a start bit only if the line still reads low at mid-bit. After that start bit the receiver decides each following bit by a majority vote of three samples taken around the middle of the bit period. It shifts five to eight data bits into a shift register, least significant bit first, and then reads an optional parity bit.

The frame moves to a one-entry holding buffer at the middle of the first stop bit. The receiver does not wait for any later stop bit. A frame error flag and a parity error flag are stored with the word. An available flag marks that the buffer holds a word the host has not read yet, and a read strobe from the host clears it. The host must hold the configuration inputs steady while a frame is in flight. When the enable input is low, the receiver does not look at the line and throws away any frame it has only partly received.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, avail_o, frame_err_o and parity_err_o are 0 and rd_data_o is all zeros.
- R2: len_i selects the number of data bits: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. The first data bit on the line lands in rd_data_o[0], and the bits above the selected length read 0.
- R3: par_mode_i selects the parity check: 2'b10 is even, 2'b11 is odd, and 2'b00 or 2'b01 means no parity bit in the frame. With parity on, parity_err_o is set when the received parity bit differs from the XOR of the data bits (inverted for odd parity). With parity off it is 0.
- R4: frame_err_o is set when the first stop bit is decided low. The data of that frame is still stored.
- R5: A low level on the idle line starts a frame only if the line is still low at sample 8 of the 16 samples in the bit period. A shorter low pulse stores nothing, and the receiver then takes the next frame correctly.
- R6: The receiver samples the line only on os_tick_i pulses. Each bit is the majority of samples 7, 8 and 9 in its period, so an inversion that lasts one sample does not change the bit.
- R7: The frame is stored at the middle of the first stop bit, so avail_o is already 1 before that stop bit ends. Nothing after the first stop bit is examined.
- R8: avail_o sets in the cycle after a frame is stored and clears in the cycle after rd_i. When both happen in the same cycle, the store wins. rd_data_o and the error flags do not change between stores.
- R9: While rx_en_i is 0, the line is ignored. Dropping rx_en_i in the middle of a frame throws that frame away.
- R10: A new frame overwrites a buffered word the host has not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; while high the receiver owns the serial input |
| os_tick_i | input | 1 | Oversampling strobe, 16 pulses per bit |
| rxd_i | input | 1 | Serial input, idle high |
| len_i | input | 2 | Data length code (5 + value bits) |
| par_mode_i | input | 2 | Parity selection |
| rd_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Buffered data word |
| avail_o | output | 1 | Unread word present |
| frame_err_o | output | 1 | Stop bit of buffered word was low |
| parity_err_o | output | 1 | Parity mismatch on buffered word |

## Verification
The bench sends every frame length with every parity setting across a set of edge-heavy data patterns. A design that misaligns short words, shifts the wrong way or miscounts data bits leaves stray high bits or shifted values in the word. Forcing the parity bit wrong and forcing the stop bit low must each raise exactly its own flag. A design that swaps even and odd parity, or that drops the word after a framing error, fails these checks. Further cases cover a low pulse on the line that is too short to be a start bit and a one-sample glitch in the middle of a data bit. A receiver that validates the start on the edge alone, or that trusts a single sample, takes in a false frame or flips the bit. The bench also drops the enable in the middle of a frame, reads avail_o partway through the first stop bit, and leaves a word unread until the next frame arrives. A late commit, a frame kept after the receiver was disabled, or a buffer that keeps its old word all show up in these checks.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE  = 16,
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        par_mode_i,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              par_err_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int MID   = OS_RATE / 2;
  localparam logic [CNT_W-1:0] S_PRE  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] S_MID  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] S_POST = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(OS_RATE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              v_pre_q, v_mid_q, par_q;

  logic              vote;
  logic              par_on, par_exp;
  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W:0]    shamt;

  assign vote     = (v_pre_q & v_mid_q) | (v_pre_q & rx_i) | (v_mid_q & rx_i);
  assign par_on   = par_mode_i[1];
  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(len_i);
  assign shamt    = (IDX_W+1)'(DATA_W - MIN_BITS) - (IDX_W+1)'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      v_pre_q <= 1'b1;
      v_mid_q <= 1'b1;
      par_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (state_q == RX_IDLE) begin
        if (!rx_i) begin
          state_q <= RX_START;
          cnt_q   <= CNT_W'(1);
        end
      end else begin
        cnt_q <= (cnt_q == S_LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == S_PRE) v_pre_q <= rx_i;
        if (cnt_q == S_MID) v_mid_q <= rx_i;
        unique case (state_q)
          RX_START: begin
            if (cnt_q == S_MID && rx_i) state_q <= RX_IDLE; // false start
            else if (cnt_q == S_LAST) begin
              state_q <= RX_DATA;
              idx_q   <= '0;
            end
          end
          RX_DATA: begin
            if (cnt_q == S_POST) sh_q <= {vote, sh_q[DATA_W-1:1]};
            if (cnt_q == S_LAST) begin
              if (idx_q == last_idx) state_q <= par_on ? RX_PAR : RX_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt_q == S_POST) par_q   <= vote;
            if (cnt_q == S_LAST) state_q <= RX_STOP;
          end
          RX_STOP: begin
            if (cnt_q == S_POST) state_q <= RX_IDLE; // commit, later stop bits not examined
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o      = sh_q >> shamt;
  assign par_exp     = (^data_o) ^ par_mode_i[0];
  assign commit_o    = en_i && tick_i && (state_q == RX_STOP) && (cnt_q == S_POST);
  assign frame_err_o = ~vote;
  assign par_err_o   = par_on && (par_q != par_exp);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              avail_o,
  output logic              fe_o,
  output logic              pe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
      avail_o <= 1'b0;
    end else if (load_i) begin
      data_o  <= data_i;
      fe_o    <= fe_i;
      pe_o    <= pe_i;
      avail_o <= 1'b1;
    end else if (rd_i) begin
      avail_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int OS_RATE    = 16,
  parameter int DATA_W     = 8,
  parameter int MIN_BITS   = 5,
  parameter int SYNC_DEPTH = 2,
  localparam int LEN_W     = $clog2(DATA_W - MIN_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              os_tick_i,
  input  logic              rxd_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              avail_o,
  output logic              frame_err_o,
  output logic              parity_err_o
);
  logic              rx_s;
  logic              commit_w;
  logic [DATA_W-1:0] word_w;
  logic              fe_w, pe_w;

  uart_rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_rx_core #(
    .OS_RATE (OS_RATE),
    .DATA_W  (DATA_W),
    .MIN_BITS(MIN_BITS),
    .LEN_W   (LEN_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en_i),
    .tick_i     (os_tick_i),
    .rx_i       (rx_s),
    .len_i      (len_i),
    .par_mode_i (par_mode_i),
    .commit_o   (commit_w),
    .data_o     (word_w),
    .frame_err_o(fe_w),
    .par_err_o  (pe_w)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit_w),
    .data_i (word_w),
    .fe_i   (fe_w),
    .pe_i   (pe_w),
    .rd_i   (rd_i),
    .data_o (rd_data_o),
    .avail_o(avail_o),
    .fe_o   (frame_err_o),
    .pe_o   (parity_err_o)
  );
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              rd_i,
  input logic              commit_i,
  input logic [LEN_W-1:0]  len_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              avail_o,
  input logic              frame_err_o,
  input logic              parity_err_o
);
  p_store_sets_avail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> avail_o);

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !commit_i) |=> !avail_o);

  p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(rd_data_o) && $stable(frame_err_o) && $stable(parity_err_o)));

  p_avail_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_o) |-> $past(commit_i));

  p_disabled_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> !commit_i);

  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> ((rd_data_o >> (MIN_BITS + int'($past(len_i)))) == '0));
endmodule

bind uart_rx_buf uart_rx_buf_chk #(
  .DATA_W  (DATA_W),
  .MIN_BITS(MIN_BITS),
  .LEN_W   (LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .rd_i        (rd_i),
  .commit_i    (commit_w),
  .len_i       (len_i),
  .rd_data_o   (rd_data_o),
  .avail_o     (avail_o),
  .frame_err_o (frame_err_o),
  .parity_err_o(parity_err_o)
);

// File: tb/uart_rx_buf_bench.sv
`timescale 1ns/1ps
module uart_rx_buf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len = 2'd3;
  logic [1:0] pm = 2'd0;
  logic       rd = 1'b0;
  logic [7:0] dout;
  logic       avail, fe, pe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  logic mid_avail;

  always #4 clk = ~clk;
  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  uart_rx_buf u_uart_rx_buf (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_en_i     (en),
    .os_tick_i   (tick),
    .rxd_i       (rxd),
    .len_i       (len),
    .par_mode_i  (pm),
    .rd_i        (rd),
    .rd_data_o   (dout),
    .avail_o     (avail),
    .frame_err_o (fe),
    .parity_err_o(pe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <190000", cyc);
      finish_run();
    end
  end

  // two clocks per oversampling tick
  task automatic hold(input logic v, input int ticks);
    rxd = v;
    repeat (2 * ticks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input logic [1:0] mode,
                            input logic stop_v, input logic flip, input int gbit);
    logic [7:0] mask;
    logic p;
    mask = 8'((9'h1 << n) - 1);
    hold(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      if (i == gbit) begin
        hold(d[i], 7); hold(~d[i], 1); hold(d[i], 8);
      end else hold(d[i], 16);
    end
    if (mode[1]) begin
      p = (^(d & mask)) ^ mode[0] ^ flip;
      hold(p, 16);
    end
    hold(stop_v, 13);
    mid_avail = avail;
    hold(stop_v, 3);
    rxd = 1'b1;
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] pats [8];
    logic [1:0] modes [3];
    logic [7:0] m;
    pats = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h96, 8'h3C};
    modes = '{2'b00, 2'b10, 2'b11};
    repeat (4) @(negedge clk);
    chk("R1 avail", avail, 0);
    chk("R1 data", dout, 0);
    chk("R1 fe", fe, 0);
    chk("R1 pe", pe, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R2/R3 sweep over length, parity mode and data pattern
    for (int n = 5; n <= 8; n++) begin
      for (int k = 0; k < 3; k++) begin
        for (int j = 0; j < 8; j++) begin
          len = 2'(n - 5);
          pm = modes[k];
          m = 8'((9'h1 << n) - 1);
          send_frame(pats[j], n, pm, 1'b1, 1'b0, -1);
          hold(1'b1, 4);
          chk("R2 avail", avail, 1);
          chk("R2 data", dout, pats[j] & m);
          chk("R4 fe clean", fe, 0);
          chk("R3 pe clean", pe, 0);
          do_read();
          chk("R8 read clears", avail, 0);
          chk("R8 data held", dout, pats[j] & m);
        end
      end
    end

    // R3 parity mismatch, both senses
    len = 2'd3;
    for (int k = 1; k < 3; k++) begin
      pm = modes[k];
      send_frame(8'h5A, 8, pm, 1'b1, 1'b1, -1);
      hold(1'b1, 4);
      chk("R3 pe set", pe, 1);
      chk("R3 data", dout, 8'h5A);
      chk("R4 fe clear", fe, 0);
      do_read();
    end

    // R4 framing error, data still stored
    pm = 2'b00; len = 2'd2;
    send_frame(8'h63, 7, pm, 1'b0, 1'b0, -1);
    hold(1'b1, 32);
    chk("R4 fe set", fe, 1);
    chk("R4 data", dout, 8'h63);
    chk("R4 avail", avail, 1);
    do_read();

    // R5 short low pulse is not a start bit
    len = 2'd3;
    hold(1'b0, 5);
    hold(1'b1, 40);
    chk("R5 no frame", avail, 0);
    send_frame(8'hC3, 8, pm, 1'b1, 1'b0, -1);
    hold(1'b1, 4);
    chk("R5 recover", dout, 8'hC3);
    chk("R5 recover fe", fe, 0);
    do_read();

    // R6 one-sample glitch mid-bit
    for (int g = 0; g < 8; g++) begin
      send_frame(8'hA5, 8, 2'b10, 1'b1, 1'b0, g);
      hold(1'b1, 4);
      chk("R6 glitch", dout, 8'hA5);
      chk("R6 glitch pe", pe, 0);
      do_read();
    end

    // R7 store before end of first stop bit
    send_frame(8'h27, 8, 2'b00, 1'b1, 1'b0, -1);
    chk("R7 mid stop", mid_avail, 1);
    hold(1'b1, 16);
    chk("R7 data", dout, 8'h27);
    do_read();

    // R9 disabled receiver ignores line
    en = 1'b0;
    send_frame(8'h00, 8, 2'b00, 1'b1, 1'b0, -1);
    en = 1'b1;
    hold(1'b1, 8);
    chk("R9 disabled", avail, 0);
    // R9 drop enable mid-frame
    hold(1'b0, 16);
    hold(1'b1, 40);
    en = 1'b0;
    hold(1'b1, 2);
    en = 1'b1;
    hold(1'b1, 120);
    chk("R9 aborted", avail, 0);
    chk("R9 old data", dout, 8'h27);

    // R10 overwrite unread word
    send_frame(8'h11, 8, 2'b00, 1'b1, 1'b0, -1);
    hold(1'b1, 4);
    send_frame(8'hEE, 8, 2'b00, 1'b1, 1'b0, -1);
    hold(1'b1, 4);
    chk("R10 newest", dout, 8'hEE);
    chk("R10 avail", avail, 1);
    do_read();
    chk("R10 cleared", avail, 0);

    finish_run();
  end
endmodule